// File: doc/BRIEF.md
# Quad-SPI Pseudo-Static RAM Target Model

This block is a synthesizable serial RAM target. It acts like a small pseudo-static RAM on an SPI/quad-SPI bus, so a host controller can be checked against it inside a self-checking environment. The block runs on a fast system clock and oversamples the serial clock, the chip select and the four data lines.

After reset the target listens on a single data line. It only recognises the command that switches it to four-line operation. In four-line mode it takes read and write bursts, each with a 24-bit byte address. A read burst returns data after a fixed number of turnaround clocks.

Burst addresses do not advance linearly. They roll over inside a 1024-byte page, so the target keeps the aliasing that a host must avoid by splitting its transfers. Data is kept in an internal byte array.

Top module: `psram_qpi_target`

## Requirements
- R1: After reset the target is in single-line mode. Only `io_in[0]` is sampled, one bit per rising serial clock, most significant bit first. No eight-bit instruction other than 0x35 has any effect, and `io_oe` stays low.
- R2: The single-line instruction 0x35 switches the target to four-line mode. The mode persists across later transactions until reset.
- R3: In four-line mode an instruction takes two clocks, high nibble first. The address then takes six clocks, most significant nibble first. The target accepts 0x38 (write) and 0xEB (read). Only the low 11 address bits select a byte (2048 bytes by default), and the upper address bits are ignored.
- R4: Write data arrives two nibbles per byte, high nibble first. A byte is stored once both of its nibbles have arrived. A half byte that is pending when chip select rises is discarded.
- R5: A read leaves the data lines undriven for 6 turnaround clocks after the address. On each following falling serial clock it drives the next nibble, high nibble first. `io_oe` is high only in the read data phase.
- R6: Within a burst the byte address increments inside its 1024-byte page. After offset 0x3FF it returns to offset 0x000 of the same page. A write burst longer than the remainder of the page therefore overwrites the start of that page.
- R7: Raising chip select aborts any instruction, address, turnaround or data phase and drops `io_oe`. The next low chip select starts a new instruction.
- R8: A four-line instruction other than 0x38 or 0xEB is ignored until chip select rises. Nothing is written and nothing is driven.
- R9: Asserting `rst_n` returns the target to single-line mode with `io_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bus clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Serial data lines into the target |
| io_out | output | 4 | Read data nibble toward the host |
| io_oe | output | 1 | Output enable for the data lines |

## Verification
A wrong mode flag shows up within the first transaction. The target either never drives the lines after a read, or it misreads the instruction and stays silent. A miscounted turnaround or address counter moves the first returned nibble by one or more serial clocks, and this is visible on the very first read beat. A wrong page wrap stays hidden while a wrapped write is read back with the same wrap. It only shows when the page start, or the neighbouring page, is read in a separate later burst, so the tests include those reads on purpose.

// File: rtl/psram_qpi_pkg.sv
package psram_qpi_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_RDATA,
    PH_WDATA,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_ENTER_QUAD = 8'h35;
  localparam logic [7:0] OP_QWRITE     = 8'h38;
  localparam logic [7:0] OP_QREAD      = 8'hEB;

endpackage

// File: rtl/psram_pin_sync.sv
module psram_pin_sync #(
  parameter int          W       = 6,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= RST_VAL;
      end else begin
        if (s == 0) stg_q[s] <= d;
        else        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/psram_burst_addr.sv
module psram_burst_addr #(
  parameter int AW         = 11,
  parameter int PAGE_BYTES = 1024
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  if (AW > OFF_W) begin : g_paged
    logic [OFF_W-1:0] off_inc;
    assign off_inc = cur[OFF_W-1:0] + 1'b1;
    assign nxt     = {cur[AW-1:OFF_W], off_inc};
  end else begin : g_flat
    assign nxt = cur + 1'b1;
  end

endmodule

// File: rtl/psram_byte_store.sv
module psram_byte_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/psram_qpi_target.sv
module psram_qpi_target
  import psram_qpi_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 1024,
  parameter int DUMMY_CYC   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic       io_oe
);

  localparam int AW        = $clog2(MEM_BYTES);
  localparam int ADDR_NIB  = 6;
  localparam int SH_W      = 4 * ADDR_NIB;
  localparam int DUM_W     = $clog2(DUMMY_CYC + 1);
  localparam int CNT_W     = (DUM_W > 3) ? DUM_W : 3;

  // synchronised pins: {cs, sclk, io}
  logic [5:0] pins_s;
  logic       cs_s, sclk_s;
  logic [3:0] io_s;

  psram_pin_sync #(
    .W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b100000)
  ) sync_i (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, io_in}), .q(pins_s)
  );

  assign cs_s   = pins_s[5];
  assign sclk_s = pins_s[4];
  assign io_s   = pins_s[3:0];

  // state
  phase_e          phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0] sh_q, sh_d;
  logic            quad_q, quad_d;
  logic            rd_q, rd_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            nib_hi_q, nib_hi_d;
  logic [3:0]      hold_q, hold_d;
  logic [3:0]      io_out_q, io_out_d;
  logic            oe_q, oe_d;
  logic            sclk_q;

  logic            rise, fall;
  logic [AW-1:0]   addr_nxt;
  logic [7:0]      rdata;
  logic            we;
  logic [7:0]      cmd_spi, cmd_quad;
  logic [SH_W-1:0] sh_spi, sh_quad;

  assign rise = sclk_s & ~sclk_q & ~cs_s;
  assign fall = ~sclk_s & sclk_q & ~cs_s;

  psram_burst_addr #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) wrap_i (
    .cur(addr_q), .nxt(addr_nxt)
  );

  assign we = rise & (phase_q == PH_WDATA) & ~nib_hi_q;

  psram_byte_store #(.DEPTH(MEM_BYTES), .AW(AW)) store_i (
    .clk(clk), .we(we), .waddr(addr_q), .wdata({hold_q, io_s}),
    .raddr(addr_q), .rdata(rdata)
  );

  assign sh_spi   = (sh_q << 1) | {{(SH_W-1){1'b0}}, io_s[0]};
  assign sh_quad  = (sh_q << 4) | {{(SH_W-4){1'b0}}, io_s};
  assign cmd_spi  = 8'(sh_spi);
  assign cmd_quad = 8'(sh_quad);

  // next-state
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    quad_d   = quad_q;
    rd_d     = rd_q;
    addr_d   = addr_q;
    nib_hi_d = nib_hi_q;
    hold_d   = hold_q;
    io_out_d = io_out_q;
    oe_d     = oe_q;
    if (cs_s) begin
      phase_d  = PH_CMD;
      cnt_d    = '0;
      oe_d     = 1'b0;
      nib_hi_d = 1'b1;
    end else if (rise) begin
      unique case (phase_q)
        PH_CMD: begin
          cnt_d = cnt_q + 1'b1;
          if (!quad_q) begin
            sh_d = sh_spi;
            if (cnt_q == CNT_W'(7)) begin
              cnt_d   = '0;
              phase_d = PH_SKIP;
              if (cmd_spi == OP_ENTER_QUAD) quad_d = 1'b1;
            end
          end else begin
            sh_d = sh_quad;
            if (cnt_q == CNT_W'(1)) begin
              cnt_d = '0;
              if (cmd_quad == OP_QREAD) begin
                rd_d    = 1'b1;
                phase_d = PH_ADDR;
              end else if (cmd_quad == OP_QWRITE) begin
                rd_d    = 1'b0;
                phase_d = PH_ADDR;
              end else begin
                phase_d = PH_SKIP;
              end
            end
          end
        end
        PH_ADDR: begin
          sh_d  = sh_quad;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_NIB - 1)) begin
            cnt_d    = '0;
            addr_d   = AW'(sh_quad);
            nib_hi_d = 1'b1;
            if (!rd_q)               phase_d = PH_WDATA;
            else if (DUMMY_CYC == 0) phase_d = PH_RDATA;
            else                     phase_d = PH_DUMMY;
          end
        end
        PH_DUMMY: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DUMMY_CYC - 1)) begin
            cnt_d   = '0;
            phase_d = PH_RDATA;
          end
        end
        PH_WDATA: begin
          if (nib_hi_q) begin
            hold_d   = io_s;
            nib_hi_d = 1'b0;
          end else begin
            nib_hi_d = 1'b1;
            addr_d   = addr_nxt;
          end
        end
        default: ;
      endcase
    end else if (fall && (phase_q == PH_RDATA)) begin
      io_out_d = nib_hi_q ? rdata[7:4] : rdata[3:0];
      oe_d     = 1'b1;
      nib_hi_d = ~nib_hi_q;
      if (!nib_hi_q) addr_d = addr_nxt;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      sh_q     <= '0;
      quad_q   <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      nib_hi_q <= 1'b1;
      hold_q   <= '0;
      io_out_q <= '0;
      oe_q     <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      quad_q   <= quad_d;
      rd_q     <= rd_d;
      addr_q   <= addr_d;
      nib_hi_q <= nib_hi_d;
      hold_q   <= hold_d;
      io_out_q <= io_out_d;
      oe_q     <= oe_d;
      sclk_q   <= sclk_s;
    end
  end

  assign io_out = io_out_q;
  assign io_oe  = oe_q;

endmodule

// File: rtl/psram_qpi_target_chk.sv
module psram_qpi_target_chk
  import psram_qpi_pkg::*;
#(
  parameter int AW    = 11,
  parameter int OFF_W = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input phase_e        phase,
  input logic          quad,
  input logic          io_oe,
  input logic          we,
  input logic [AW-1:0] addr
);

  // R5
  oe_in_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (phase == PH_RDATA));

  // R2
  quad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad |=> quad);

  // R1
  spi_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !quad |-> !io_oe);

  // R7
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> ((phase == PH_CMD) && !io_oe));

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!io_oe && !we));

  if (AW > OFF_W) begin : g_page
    // R6
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_WDATA) || (phase == PH_RDATA)) |=> $stable(addr[AW-1:OFF_W]));
  end

endmodule

bind psram_qpi_target psram_qpi_target_chk #(
  .AW(AW), .OFF_W($clog2(PAGE_BYTES))
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .phase(phase_q),
  .quad(quad_q), .io_oe(io_oe), .we(we), .addr(addr_q)
);

// File: tb/psram_qpi_target_tb.sv
module psram_qpi_target_tb_top;

  localparam int DUMMY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] io_drv = 4'h0;
  logic [3:0] io_out;
  logic       io_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic oe_seen = 1'b0;
  logic done = 1'b0;
  logic [7:0] exp_mem [0:2047];

  always #2.5 clk = ~clk;

  psram_qpi_target #(.DUMMY_CYC(DUMMY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .io_in(io_drv), .io_out(io_out), .io_oe(io_oe)
  );

  function automatic int unsigned bidx(int unsigned a, int unsigned i);
    return (a & 32'h400) | ((a + i) & 32'h3FF);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clk_nib(input logic [3:0] d, output logic [3:0] q, output logic oe);
    @(negedge clk);
    sclk = 1'b0;
    io_drv = d;
    repeat (4) @(negedge clk);
    q = io_out;
    oe = io_oe;
    if (io_oe) oe_seen = 1'b1;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_nib(input logic [3:0] d);
    logic [3:0] q; logic oe;
    clk_nib(d, q, oe);
  endtask

  task automatic send_qbyte(input logic [7:0] b);
    send_nib(b[7:4]);
    send_nib(b[3:0]);
  endtask

  task automatic send_sbyte(input logic [7:0] b, input logic [2:0] junk);
    for (int i = 7; i >= 0; i--) send_nib({junk, b[i]});
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk);
    sclk = 1'b0;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic quad_hdr(input logic [7:0] op, input logic [23:0] a);
    send_qbyte(op);
    for (int k = 5; k >= 0; k--) send_nib(a[4*k +: 4]);
  endtask

  task automatic quad_write(input logic [23:0] a, input int n, input logic [7:0] seed);
    cs_low();
    quad_hdr(8'h38, a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 37);
      send_qbyte(b);
      exp_mem[bidx(a & 24'h7FF, i)] = b;
    end
    cs_high();
  endtask

  task automatic quad_read(input logic [23:0] a, input int n, input string req);
    logic [3:0] hi, lo; logic oe1, oe2;
    cs_low();
    quad_hdr(8'hEB, a);
    for (int i = 0; i < DUMMY; i++) begin
      clk_nib(4'h0, hi, oe1);
      check(oe1 == 1'b0, "R5 turnaround undriven", oe1, 0);
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_mem[bidx(a & 24'h7FF, i)];
      clk_nib(4'h0, hi, oe1);
      clk_nib(4'h0, lo, oe2);
      check(oe1 && oe2, "R5 data driven", {oe1, oe2}, 3);
      check({hi, lo} == e, req, {hi, lo}, e);
    end
    cs_high();
    check(io_oe == 1'b0, "R5 released after cs", io_oe, 0);
  endtask

  task automatic t_reset();
    check(io_oe == 1'b0, "R9 reset oe", io_oe, 0);
  endtask

  task automatic t_spi_mode();
    oe_seen = 1'b0;
    cs_low();
    quad_hdr(8'hEB, 24'h000010);
    for (int i = 0; i < 20; i++) send_nib(4'hF);
    cs_high();
    check(oe_seen == 1'b0, "R1 spi ignores quad read", oe_seen, 0);
  endtask

  task automatic t_enter_quad();
    cs_low();
    send_sbyte(8'h35, 3'b110);
    cs_high();
    quad_write(24'h000010, 8, 8'h3C);
    quad_read(24'h000010, 8, "R2 quad after enter");
    quad_read(24'h000012, 3, "R3 read mid burst addr");
  endtask

  task automatic t_high_addr();
    quad_write(24'hAB0123, 4, 8'hA5);
    quad_read(24'h000123, 4, "R3 upper addr bits ignored");
  endtask

  task automatic t_wrap();
    quad_write(24'h000400, 4, 8'h11);
    quad_write(24'h0003FA, 12, 8'hC7);
    quad_read(24'h000000, 6, "R6 page start overwritten");
    quad_read(24'h0003FA, 6, "R6 page tail");
    quad_read(24'h000400, 4, "R6 next page untouched");
    quad_write(24'h0007FC, 2, 8'h5E);
    quad_read(24'h0007FE, 4, "R6 read wraps to page start");
  endtask

  task automatic t_partial();
    quad_write(24'h000100, 2, 8'h90);
    cs_low();
    quad_hdr(8'h38, 24'h000100);
    send_qbyte(8'h5A);
    send_nib(4'hC);
    cs_high();
    exp_mem[12'h100] = 8'h5A;
    quad_read(24'h000100, 2, "R4 half byte dropped");
  endtask

  task automatic t_abort();
    logic [3:0] q; logic oe;
    cs_low();
    send_qbyte(8'h38);
    send_nib(4'h0); send_nib(4'h0); send_nib(4'h0);
    cs_high();
    quad_read(24'h000100, 2, "R7 new instr after addr abort");
    cs_low();
    quad_hdr(8'hEB, 24'h000100);
    for (int i = 0; i < DUMMY + 1; i++) clk_nib(4'h0, q, oe);
    check(oe == 1'b1, "R7 read started", oe, 1);
    cs_high();
    check(io_oe == 1'b0, "R7 abort drops oe", io_oe, 0);
    quad_read(24'h000010, 2, "R7 new instr after data abort");
  endtask

  task automatic t_unknown();
    oe_seen = 1'b0;
    cs_low();
    quad_hdr(8'h99, 24'h000100);
    for (int i = 0; i < 3; i++) send_qbyte(8'hFF);
    cs_high();
    check(oe_seen == 1'b0, "R8 unknown not driven", oe_seen, 0);
    cs_low();
    quad_hdr(8'h35, 24'h000101);
    send_qbyte(8'hFF);
    cs_high();
    check(oe_seen == 1'b0, "R8 enter cmd in quad not driven", oe_seen, 0);
    quad_read(24'h000100, 2, "R8 unknown wrote nothing");
  endtask

  task automatic t_reset_mode();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(io_oe == 1'b0, "R9 oe after reset", io_oe, 0);
    oe_seen = 1'b0;
    cs_low();
    quad_hdr(8'hEB, 24'h000010);
    for (int i = 0; i < 12; i++) send_nib(4'h0);
    cs_high();
    check(oe_seen == 1'b0, "R9 back in single-line mode", oe_seen, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_spi_mode();
    t_enter_quad();
    t_high_addr();
    t_wrap();
    t_partial();
    t_abort();
    t_unknown();
    t_reset_mode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule